// File: doc/BRIEF.md
# Effective Address Generator

This unit works out the 16-bit memory address that an 8-bit processor instruction refers to. The decode stage hands it one request: a mode code, the one or two operand bytes that follow the opcode, the two index register values and the address of the following instruction. The unit returns the effective address, a one-cycle completion strobe and a flag that tells whether an indexed or branch addition moved into a different 256-byte page. The instruction itself is executed elsewhere.

Register-only modes (page zero, page zero indexed, full address, full address indexed, branch offset) finish one clock after acceptance. The three pointer modes first fetch a two-byte pointer through a simple read port: one read per cycle, with data returned in the cycle after the request. Requests arrive on a valid/ready handshake. Ready is high whenever the unit is not fetching a pointer. A request is taken on a clock edge where valid and ready are both high. While ready is low, the upstream stage must hold its request, and anything on the request pins is ignored. The result side has no back-pressure: the done strobe is a plain pulse, and the address and page flag stay unchanged until the next result.

Top module: `eff_addr_unit`

## Requirements
- R1: Mode code 0 (page zero) yields address {0x00, low operand}, page flag 0, with done high in the first cycle after acceptance.
- R2: Mode codes 1 (page zero + X) and 2 (page zero + Y) yield {0x00, (low operand + index) mod 256}. The carry is dropped and the page flag is 0.
- R3: Mode code 3 (full address) yields {high operand, low operand} with page flag 0. Unused codes 10 to 15 behave the same way.
- R4: Mode codes 4 (full + X) and 5 (full + Y) yield ({high, low} + index) mod 65536, with the index zero-extended. The page flag is 1 exactly when the upper byte of the result differs from the high operand.
- R5: Mode code 9 (branch) yields (next-instruction address + low operand taken as a signed value from -128 to +127) mod 65536. The page flag is 1 exactly when the upper byte differs from that of the next-instruction address.
- R6: Mode code 6 (X-indexed pointer) reads the pointer low byte at {0x00, (low operand + X) mod 256} and the pointer high byte at {0x00, (low operand + X + 1) mod 256}. The result is {high byte, low byte}, with page flag 0.
- R7: Mode code 7 (pointer then Y) reads the pointer low byte at {0x00, low operand} and the pointer high byte at {0x00, (low operand + 1) mod 256}. The result is the pointer plus Y, with the carry going into the upper byte. The page flag is 1 when the upper byte of the result differs from the pointer's upper byte.
- R8: Mode code 8 (full pointer) reads the target low byte at {high, low} and the target high byte at ({high, low} + 1) mod 65536. The result is {target high, target low}, with page flag 0.
- R9: For pointer modes, the read strobe is high in the first and second cycles after acceptance (low-byte address first), and done is high in the fourth cycle. For the other modes no read is issued.
- R10: Ready falls in the cycle after a pointer-mode request is accepted and returns in the cycle done is high. While ready is low, the request pins are ignored: the pending result is unchanged and no extra done appears.
- R11: Done is high for exactly one cycle per accepted request. Address and page flag keep their value until the next done. Register-only requests held valid on consecutive cycles each complete on consecutive cycles.
- R12: After reset, done, the read strobe, the address and the page flag are 0, and ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_mode | input | 4 | Addressing mode code |
| req_op_lo | input | 8 | First operand byte (low address, pointer or branch offset) |
| req_op_hi | input | 8 | Second operand byte (high address) |
| req_x | input | 8 | X index value |
| req_y | input | 8 | Y index value |
| req_pc | input | 16 | Address of the next instruction |
| mem_rd_en | output | 1 | Read strobe to memory |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| done | output | 1 | Result valid this cycle |
| ea | output | 16 | Effective address |
| page_cross | output | 1 | Indexed or branch addition changed the upper byte |

## Verification
Each mode is tried with operands that stay inside a page and with operands that carry out of it. This shows whether the carry is dropped (page-zero modes) or propagated and flagged (full indexed, branch, pointer-then-Y). Branch offsets at +127, -128 and small negative values separate sign extension from zero extension. Pointer bytes at 0xFF show whether the second fetch wraps inside page zero or advances into the next page, since the bench memory returns a value that depends on the full address. Requests driven while the unit is busy, and register-only requests held valid back to back, exercise the handshake rules.

// File: rtl/eau_pkg.sv
package eau_pkg;
  typedef enum logic [3:0] {
    AM_ZP   = 4'd0,
    AM_ZPX  = 4'd1,
    AM_ZPY  = 4'd2,
    AM_ABS  = 4'd3,
    AM_ABSX = 4'd4,
    AM_ABSY = 4'd5,
    AM_INDX = 4'd6,
    AM_INDY = 4'd7,
    AM_IND  = 4'd8,
    AM_REL  = 4'd9
  } am_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_LO   = 2'd1,
    FS_HI   = 2'd2,
    FS_FIN  = 2'd3
  } fs_e;
endpackage

// File: rtl/eau_offset_add.sv
module eau_offset_add #(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] offs,
  input  logic          sign_ext,
  input  logic          keep_page,
  output logic [AW-1:0] sum,
  output logic          crossed
);
  localparam int HW = AW - DW;

  logic [AW-1:0] ext;
  logic [AW-1:0] raw;

  always_comb begin
    ext = sign_ext ? {{HW{offs[DW-1]}}, offs} : {{HW{1'b0}}, offs};
    raw = base + ext;
    sum = keep_page ? {base[AW-1:DW], raw[DW-1:0]} : raw;
    crossed = (sum[AW-1:DW] != base[AW-1:DW]);
  end
endmodule

// File: rtl/eau_fetch_seq.sv
module eau_fetch_seq
  import eau_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] lo_addr,
  input  logic [AW-1:0] hi_addr,
  input  logic [DW-1:0] rdata,
  output logic          busy,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          fin,
  output logic [DW-1:0] lo_byte
);
  fs_e           state;
  logic [AW-1:0] lo_q;
  logic [AW-1:0] hi_q;
  logic [DW-1:0] lo_byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= FS_IDLE;
      lo_q      <= '0;
      hi_q      <= '0;
      lo_byte_q <= '0;
    end else begin
      unique case (state)
        FS_IDLE: if (start) begin
          state <= FS_LO;
          lo_q  <= lo_addr;
          hi_q  <= hi_addr;
        end
        FS_LO:  state <= FS_HI;
        FS_HI: begin
          lo_byte_q <= rdata;
          state     <= FS_FIN;
        end
        FS_FIN: state <= FS_IDLE;
        default: state <= FS_IDLE;
      endcase
    end
  end

  always_comb begin
    busy    = (state != FS_IDLE);
    rd_en   = (state == FS_LO) || (state == FS_HI);
    rd_addr = (state == FS_HI) ? hi_q : lo_q;
    fin     = (state == FS_FIN);
    lo_byte = lo_byte_q;
  end

  // R9: the high-byte read follows the low-byte read directly
  a_r9_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FS_LO) |=> (rd_en && rd_addr == $past(hi_q)));

  // R9: start from idle leads to a read in the next cycle
  a_r9_read_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (rd_en && rd_addr == $past(lo_addr)));
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import eau_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2 * DW,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [MW-1:0] req_mode,
  input  logic [DW-1:0] req_op_lo,
  input  logic [DW-1:0] req_op_hi,
  input  logic [DW-1:0] req_x,
  input  logic [DW-1:0] req_y,
  input  logic [AW-1:0] req_pc,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          page_cross
);
  localparam int HW = AW - DW;
  localparam logic [HW-1:0] PAGE0 = '0;

  logic          accept;
  logic          is_ind;
  logic [AW-1:0] d_base;
  logic [DW-1:0] d_off;
  logic          d_sext;
  logic          d_keep;
  logic [AW-1:0] d_sum;
  logic          d_cross;
  logic [DW-1:0] zp_idx;
  logic [AW-1:0] p_lo_addr;
  logic [AW-1:0] p_hi_addr;
  logic          f_busy;
  logic          f_fin;
  logic [DW-1:0] f_lo_byte;
  logic [AW-1:0] f_ptr;
  logic [AW-1:0] f_sum;
  logic          f_cross;
  logic [DW-1:0] y_q;
  logic          indy_q;
  logic          done_q;
  logic [AW-1:0] ea_q;
  logic          pcross_q;

  assign req_ready = !f_busy;
  assign accept    = req_valid && req_ready;

  always_comb begin
    is_ind = (req_mode == AM_INDX) || (req_mode == AM_INDY) || (req_mode == AM_IND);
    d_base = {req_op_hi, req_op_lo};
    d_off  = '0;
    d_sext = 1'b0;
    d_keep = 1'b0;
    unique case (req_mode)
      AM_ZP:   begin d_base = {PAGE0, req_op_lo}; d_keep = 1'b1; end
      AM_ZPX:  begin d_base = {PAGE0, req_op_lo}; d_off = req_x; d_keep = 1'b1; end
      AM_ZPY:  begin d_base = {PAGE0, req_op_lo}; d_off = req_y; d_keep = 1'b1; end
      AM_ABSX: d_off = req_x;
      AM_ABSY: d_off = req_y;
      AM_REL:  begin d_base = req_pc; d_off = req_op_lo; d_sext = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    zp_idx    = req_op_lo + req_x;
    p_lo_addr = {req_op_hi, req_op_lo};
    p_hi_addr = {req_op_hi, req_op_lo} + 1'b1;
    if (req_mode == AM_INDX) begin
      p_lo_addr = {PAGE0, zp_idx};
      p_hi_addr = {PAGE0, zp_idx + 1'b1};
    end else if (req_mode == AM_INDY) begin
      p_lo_addr = {PAGE0, req_op_lo};
      p_hi_addr = {PAGE0, req_op_lo + 1'b1};
    end
  end

  eau_offset_add #(.DW(DW), .AW(AW)) i_direct_add (
    .base      (d_base),
    .offs      (d_off),
    .sign_ext  (d_sext),
    .keep_page (d_keep),
    .sum       (d_sum),
    .crossed   (d_cross)
  );

  eau_fetch_seq #(.DW(DW), .AW(AW)) i_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept && is_ind),
    .lo_addr (p_lo_addr),
    .hi_addr (p_hi_addr),
    .rdata   (mem_rdata),
    .busy    (f_busy),
    .rd_en   (mem_rd_en),
    .rd_addr (mem_addr),
    .fin     (f_fin),
    .lo_byte (f_lo_byte)
  );

  assign f_ptr = {mem_rdata, f_lo_byte};

  eau_offset_add #(.DW(DW), .AW(AW)) i_post_add (
    .base      (f_ptr),
    .offs      (y_q),
    .sign_ext  (1'b0),
    .keep_page (1'b0),
    .sum       (f_sum),
    .crossed   (f_cross)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_q      <= '0;
      indy_q   <= 1'b0;
      done_q   <= 1'b0;
      ea_q     <= '0;
      pcross_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept && is_ind) begin
        y_q    <= req_y;
        indy_q <= (req_mode == AM_INDY);
      end
      if (accept && !is_ind) begin
        done_q   <= 1'b1;
        ea_q     <= d_sum;
        pcross_q <= d_cross;
      end else if (f_fin) begin
        done_q   <= 1'b1;
        ea_q     <= indy_q ? f_sum : f_ptr;
        pcross_q <= indy_q && f_cross;
      end
    end
  end

  assign done       = done_q;
  assign ea         = ea_q;
  assign page_cross = pcross_q;

  // R1: page-zero result lands in page zero one cycle after acceptance
  a_r1_zp_page: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode == AM_ZP) |=> (done && ea[AW-1:DW] == PAGE0 && !page_cross));

  // R2: indexed page-zero result never leaves page zero
  a_r2_zp_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_mode == AM_ZPX || req_mode == AM_ZPY)) |=>
      (done && ea[AW-1:DW] == PAGE0 && !page_cross));

  // R3: full address passes the operands straight through
  a_r3_abs_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode == AM_ABS) |=>
      (done && ea == {$past(req_op_hi), $past(req_op_lo)} && !page_cross));

  // R10: pointer request drops ready in the next cycle
  a_r10_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_ind) |=> (!req_ready && !done));

  // R9: register-only requests issue no memory read
  a_r9_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_ind) |=> !mem_rd_en);
endmodule

// File: tb/test_eff_addr_unit.sv
module test_eff_addr_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_mode = '0;
  logic [7:0]  req_op_lo = '0;
  logic [7:0]  req_op_hi = '0;
  logic [7:0]  req_x = '0;
  logic [7:0]  req_y = '0;
  logic [15:0] req_pc = '0;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        done;
  logic [15:0] ea;
  logic        page_cross;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int rd_n = 0;
  logic [15:0] rd_log [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  eff_addr_unit i_eff_addr_unit (
    .clk, .rst_n, .req_valid, .req_ready, .req_mode, .req_op_lo, .req_op_hi,
    .req_x, .req_y, .req_pc, .mem_rd_en, .mem_addr, .mem_rdata, .done, .ea, .page_cross
  );

  function automatic logic [7:0] mv(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mv(mem_addr);
      rd_log[rd_n % 64] <= mem_addr;
      rd_n <= rd_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [7:0] x, input logic [7:0] y, input logic [15:0] pc,
                         input string req);
    logic [15:0] e_ea, a0, a1, p;
    logic        e_pc;
    bit          ind;
    int          lat, n0;
    ind = 0; e_pc = 0; a0 = 0; a1 = 0;
    case (m)
      4'd0: e_ea = {8'h00, lo};
      4'd1: e_ea = {8'h00, 8'(lo + x)};
      4'd2: e_ea = {8'h00, 8'(lo + y)};
      4'd4: begin e_ea = {hi, lo} + {8'h00, x}; e_pc = (e_ea[15:8] != hi); end
      4'd5: begin e_ea = {hi, lo} + {8'h00, y}; e_pc = (e_ea[15:8] != hi); end
      4'd9: begin e_ea = pc + {{8{lo[7]}}, lo}; e_pc = (e_ea[15:8] != pc[15:8]); end
      4'd6: begin ind = 1; a0 = {8'h00, 8'(lo + x)}; a1 = {8'h00, 8'(lo + x + 8'd1)};
                  e_ea = {mv(a1), mv(a0)}; end
      4'd7: begin ind = 1; a0 = {8'h00, lo}; a1 = {8'h00, 8'(lo + 8'd1)};
                  p = {mv(a1), mv(a0)}; e_ea = p + {8'h00, y}; e_pc = (e_ea[15:8] != p[15:8]); end
      4'd8: begin ind = 1; a0 = {hi, lo}; a1 = {hi, lo} + 16'd1; e_ea = {mv(a1), mv(a0)}; end
      default: e_ea = {hi, lo};
    endcase
    @(negedge clk);
    req_mode = m; req_op_lo = lo; req_op_hi = hi; req_x = x; req_y = y; req_pc = pc;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    n0 = rd_n;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    chk({req, " latency"}, lat, ind ? 4 : 1);
    chk({req, " ea"}, e_ea, ea);
    chk({req, " page_cross"}, page_cross, e_pc);
    chk({req, " R9 read count"}, rd_n - n0, ind ? 2 : 0);
    if (ind) begin
      chk({req, " low-byte read addr"}, rd_log[n0 % 64], a0);
      chk({req, " high-byte read addr"}, rd_log[(n0 + 1) % 64], a1);
    end
    @(negedge clk);
    chk({req, " R11 done one cycle"}, done, 1'b0);
    chk({req, " R11 ea held"}, ea, e_ea);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R12 done", done, 1'b0);
    chk("R12 rd_en", mem_rd_en, 1'b0);
    chk("R12 ea", ea, 16'h0000);
    chk("R12 page_cross", page_cross, 1'b0);
    chk("R12 ready", req_ready, 1'b1);
    rst_n = 1'b1;
  endtask

  task automatic t_zp();
    run_one(4'd0, 8'h80, 8'h77, 8'h11, 8'h22, 16'h4000, "R1 zp");
    run_one(4'd0, 8'hFF, 8'hAB, 8'h00, 8'h00, 16'h0000, "R1 zp top");
  endtask

  task automatic t_zp_idx();
    run_one(4'd1, 8'hF0, 8'h55, 8'h20, 8'h00, 16'h0000, "R2 zpx wrap");
    run_one(4'd2, 8'h10, 8'h55, 8'hFF, 8'h05, 16'h0000, "R2 zpy");
    run_one(4'd2, 8'h80, 8'h00, 8'h00, 8'h80, 16'h0000, "R2 zpy wrap zero");
  endtask

  task automatic t_abs();
    run_one(4'd3, 8'h34, 8'h12, 8'h01, 8'h02, 16'h0000, "R3 abs");
    run_one(4'd12, 8'h78, 8'h56, 8'h01, 8'h02, 16'h0000, "R3 unused code");
  endtask

  task automatic t_abs_idx();
    run_one(4'd4, 8'hF0, 8'h12, 8'h20, 8'h00, 16'h0000, "R4 absx cross");
    run_one(4'd5, 8'h00, 8'h12, 8'h00, 8'h05, 16'h0000, "R4 absy same page");
    run_one(4'd4, 8'hFF, 8'hFF, 8'h01, 8'h00, 16'h0000, "R4 absx wrap top");
  endtask

  task automatic t_rel();
    run_one(4'd9, 8'h10, 8'h00, 8'h00, 8'h00, 16'h2080, "R5 rel fwd");
    run_one(4'd9, 8'h80, 8'h00, 8'h00, 8'h00, 16'h2080, "R5 rel -128");
    run_one(4'd9, 8'hF0, 8'h00, 8'h00, 8'h00, 16'h2005, "R5 rel back cross");
    run_one(4'd9, 8'h7F, 8'h00, 8'h00, 8'h00, 16'h20F0, "R5 rel +127 cross");
  endtask

  task automatic t_ptr();
    run_one(4'd6, 8'hFE, 8'h33, 8'h01, 8'h00, 16'h0000, "R6 indx wrap hi");
    run_one(4'd6, 8'h40, 8'h33, 8'hC5, 8'h00, 16'h0000, "R6 indx carry drop");
    run_one(4'd7, 8'hFF, 8'h33, 8'h00, 8'hC0, 16'h0000, "R7 indy wrap");
    run_one(4'd7, 8'h21, 8'h33, 8'h00, 8'h01, 16'h0000, "R7 indy small");
    run_one(4'd8, 8'hFF, 8'h12, 8'h00, 8'h00, 16'h0000, "R8 ind page step");
  endtask

  task automatic t_busy_ignore();
    logic [15:0] a0, a1;
    a0 = 16'h5634; a1 = 16'h5635;
    @(negedge clk);
    req_mode = 4'd8; req_op_lo = 8'h34; req_op_hi = 8'h56; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R10 ready low", req_ready, 1'b0);
    req_mode = 4'd0; req_op_lo = 8'h99; req_op_hi = 8'h00;
    @(negedge clk);
    chk("R10 ready still low", req_ready, 1'b0);
    req_op_lo = 8'h42;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10 done after busy", done, 1'b1);
    chk("R10 ready back", req_ready, 1'b1);
    chk("R10 result unaffected", ea, {mv(a1), mv(a0)});
    repeat (3) begin
      @(negedge clk);
      chk("R10 no extra done", done, 1'b0);
    end
  endtask

  task automatic t_back2back();
    @(negedge clk);
    req_mode = 4'd0; req_op_lo = 8'h11; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_mode = 4'd3; req_op_lo = 8'h22; req_op_hi = 8'h33;
    chk("R11 first done", done, 1'b1);
    chk("R11 first ea", ea, 16'h0011);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 second done", done, 1'b1);
    chk("R11 second ea", ea, 16'h3322);
    @(negedge clk);
    chk("R11 done drops", done, 1'b0);
    chk("R11 ea kept", ea, 16'h3322);
  endtask

  initial begin
    t_reset();
    t_zp();
    t_zp_idx();
    t_abs();
    t_abs_idx();
    t_rel();
    t_ptr();
    t_busy_ignore();
    t_back2back();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule